// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 64-entry, 36-bit first-in first-out buffer. It moves words from a producer port on one clock to a consumer port on a second clock. The two clocks may be unrelated or may be the same clock. The write side reports whether the buffer is full or nearly full, and those two flags are timed by the write clock. The read side reports whether the buffer is empty or nearly empty, and those two flags are timed by the read clock. All four flags are active low. The consumer gets its data from a register, which is loaded on the clock edge that performs the read.

Each side keeps its own binary pointer and a Gray-coded copy of it. The Gray copy crosses into the other clock domain through a register. Each side then builds its flag registers from its own next pointer and from the pointer it received. A two-bit select input chooses one near-threshold offset X, which both nearly-full and nearly-empty use. Each domain captures the select on the first clock edge of its own that sees reset released. Reset is synchronous. It must be held low across at least four rising edges of each clock.

Top module: `dcf_top`

## Requirements
- R1: While `rst_n` is held low across at least four edges of each clock, the outputs are `full_n`=0, `aempty_n`=0, `empty_n`=0 and `afull_n`=1.
- R2: The first write-clock edge that samples `rst_n` high leaves `full_n` at 0. The second such edge drives `full_n` to 1.
- R3: A write happens on a `wclk` edge when `a_cs_n`=0, `a_en`=1, `a_wr`=1 and `full_n`=1. A read happens on an `rclk` edge when `b_cs_n`=0, `b_en`=1, `b_wr`=0 and `empty_n`=1. Words come out on `b_dout` in the order they were written, and `b_dout` is loaded on the edge that performs the read.
- R4: After a word is written into an empty buffer, the first read-clock edge after the write leaves `empty_n` at 0. The second read-clock edge drives `empty_n` to 1.
- R5: Once the flags have settled, `aempty_n` is 0 when the stored word count is at most X, and 1 otherwise.
- R6: Once the flags have settled, `afull_n` is 0 when the number of free entries is at most X, and 1 otherwise.
- R7: With 64 words stored, `full_n` is 0. A further write attempt is dropped: it changes neither the content nor the pointer.
- R8: The edge that reads the last stored word drives `empty_n` to 0. A read attempt while `empty_n`=0 is dropped, and `b_dout` holds its value.
- R9: The value on `off_sel` when reset is released picks X: 00 gives 16, 01 gives 12, 10 gives 8 and 11 gives 4. Changes to `off_sel` after release have no effect.
- R10: A port-A cycle with `a_cs_n`=1, `a_en`=0 or `a_wr`=0 stores nothing. A port-B cycle with `b_wr`=1 or `b_cs_n`=1 reads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous reset, active low, seen by both domains |
| off_sel | input | 2 | Offset select, captured when reset is released |
| a_cs_n | input | 1 | Port A select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_din | input | 36 | Write data |
| full_n | output | 1 | Full flag, active low, timed by wclk |
| afull_n | output | 1 | Nearly-full flag, active low, timed by wclk |
| b_cs_n | input | 1 | Port B select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_dout | output | 36 | Registered read data |
| empty_n | output | 1 | Empty flag, active low, timed by rclk |
| aempty_n | output | 1 | Nearly-empty flag, active low, timed by rclk |

## Verification
The bench writes a single word into an empty buffer and checks the empty flag on each of the next two read edges. This catches any added or missing stage on the pointer crossing. A fill-to-capacity run steps across the thresholds one word at a time, and the pattern shows off-by-one errors in both near-flag comparisons. It also shows whether a write attempted on a full buffer leaks through. A run over all four offset selects, with the select changed after release, separates the preset mapping from the capture timing. A streaming run with a slower, unrelated read clock and flag-paced traffic on both ports exercises the Gray crossing and the ordering of the data.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    // Gray-to-binary conversion for any width up to 32 (zero-extend the input)
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

    // Preset threshold picked by the two-bit select
    function automatic logic [31:0] pick_offset(input logic [1:0] s,
                                                input int unsigned base,
                                                input int unsigned step);
        return 32'(base - step * 32'(s));
    endfunction

endpackage

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW       = 6,
    parameter int OFF_BASE = 16,
    parameter int OFF_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [1:0]    sel,
    input  logic [AW:0]   rgray_in,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n
);
    localparam int           PW      = AW + 1;
    localparam logic [AW:0]  DEPTH_V = PW'(1 << AW);

    typedef struct packed {
        logic        rs;
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic [AW:0] rsync;
        logic [AW:0] off;
        logic        full_n;
        logic        afull_n;
    } wst_t;

    wst_t        st_q, st_d;
    logic        do_wr;
    logic [AW:0] rbin, used, free;

    always_comb begin
        st_d  = st_q;
        do_wr = st_q.rs & wr_req & st_q.full_n;
        rbin  = PW'(gray_to_bin(32'(st_q.rsync)));
        used  = '0;
        free  = '0;
        if (!rst_n) begin
            do_wr        = 1'b0;
            st_d.rs      = 1'b0;
            st_d.bin     = '0;
            st_d.gray    = '0;
            st_d.rsync   = '0;
            st_d.off     = PW'(pick_offset(sel, OFF_BASE, OFF_STEP));
            st_d.full_n  = 1'b0;
            st_d.afull_n = 1'b1;
        end else begin
            st_d.rs = 1'b1;
            if (!st_q.rs) begin
                st_d.off = PW'(pick_offset(sel, OFF_BASE, OFF_STEP));
            end
            st_d.bin     = st_q.bin + {{AW{1'b0}}, do_wr};
            st_d.gray    = st_d.bin ^ (st_d.bin >> 1);
            st_d.rsync   = rgray_in;
            used         = st_d.bin - rbin;
            free         = DEPTH_V - used;
            st_d.full_n  = st_q.rs & (used != DEPTH_V);
            st_d.afull_n = ~st_q.rs | (free > st_d.off);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign we      = do_wr;
    assign waddr   = st_q.bin[AW-1:0];
    assign wgray   = st_q.gray;
    assign full_n  = st_q.full_n;
    assign afull_n = st_q.afull_n;

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rs && !st_q.full_n && wr_req) |=> (st_q.bin == $past(st_q.bin))); // R7

    AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rs && $past(st_q.rs) && !st_q.full_n) |-> !st_q.afull_n); // R6

endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 36,
    parameter int OFF_BASE = 16,
    parameter int OFF_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [1:0]    sel,
    input  logic [AW:0]   wgray_in,
    input  logic [DW-1:0] mem_data,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic          rs;
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        logic [AW:0]   wsync;
        logic [AW:0]   off;
        logic          empty_n;
        logic          aempty_n;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t        st_q, st_d;
    logic        do_rd;
    logic [AW:0] wbin, count;

    always_comb begin
        st_d  = st_q;
        do_rd = st_q.rs & rd_req & st_q.empty_n;
        wbin  = PW'(gray_to_bin(32'(st_q.wsync)));
        count = '0;
        if (!rst_n) begin
            do_rd         = 1'b0;
            st_d.rs       = 1'b0;
            st_d.bin      = '0;
            st_d.gray     = '0;
            st_d.wsync    = '0;
            st_d.off      = PW'(pick_offset(sel, OFF_BASE, OFF_STEP));
            st_d.empty_n  = 1'b0;
            st_d.aempty_n = 1'b0;
            st_d.dout     = '0;
        end else begin
            st_d.rs = 1'b1;
            if (!st_q.rs) begin
                st_d.off = PW'(pick_offset(sel, OFF_BASE, OFF_STEP));
            end
            st_d.bin      = st_q.bin + {{AW{1'b0}}, do_rd};
            st_d.gray     = st_d.bin ^ (st_d.bin >> 1);
            st_d.wsync    = wgray_in;
            st_d.dout     = do_rd ? mem_data : st_q.dout;
            count         = wbin - st_d.bin;
            st_d.empty_n  = st_q.rs & (count != '0);
            st_d.aempty_n = st_q.rs & (count > st_d.off);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign raddr    = st_q.bin[AW-1:0];
    assign rgray    = st_q.gray;
    assign dout     = st_q.dout;
    assign empty_n  = st_q.empty_n;
    assign aempty_n = st_q.aempty_n;

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.empty_n && rd_req) |=> ($stable(st_q.bin) && $stable(st_q.dout))); // R8

    AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.empty_n |-> !st_q.aempty_n); // R5

    AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rs && st_q.empty_n && rd_req) |=> (st_q.bin == PW'($past(st_q.bin) + 1'b1))); // R3

endmodule

// File: rtl/dcf_top.sv
`timescale 1ns/1ps
module dcf_top #(
    parameter int AW       = 6,
    parameter int DW       = 36,
    parameter int OFF_BASE = 16,
    parameter int OFF_STEP = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    off_sel,
    input  logic          a_cs_n,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic [DW-1:0] a_din,
    output logic          full_n,
    output logic          afull_n,
    input  logic          b_cs_n,
    input  logic          b_en,
    input  logic          b_wr,
    output logic [DW-1:0] b_dout,
    output logic          empty_n,
    output logic          aempty_n
);
    logic          wr_req, rd_req, we;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray;
    logic [DW-1:0] mem_rdata;

    assign wr_req = ~a_cs_n & a_en & a_wr;
    assign rd_req = ~b_cs_n & b_en & ~b_wr;

    dcf_wr_side #(.AW(AW), .OFF_BASE(OFF_BASE), .OFF_STEP(OFF_STEP)) u_wr (
        .clk      (wclk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .sel      (off_sel),
        .rgray_in (rgray),
        .we       (we),
        .waddr    (waddr),
        .wgray    (wgray),
        .full_n   (full_n),
        .afull_n  (afull_n)
    );

    dcf_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (a_din),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    dcf_rd_side #(.AW(AW), .DW(DW), .OFF_BASE(OFF_BASE), .OFF_STEP(OFF_STEP)) u_rd (
        .clk      (rclk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .sel      (off_sel),
        .wgray_in (wgray),
        .mem_data (mem_rdata),
        .raddr    (raddr),
        .rgray    (rgray),
        .dout     (b_dout),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );

endmodule

// File: tb/sim_dcf_top.sv
`timescale 1ns/1ps
module sim_dcf_top;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  off_sel = 2'b00;
    logic        a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0;
    logic [35:0] a_din = '0;
    logic        b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b1;
    logic [35:0] b_dout;
    logic        full_n, afull_n, empty_n, aempty_n;
    int          total = 0;
    int          bad = 0;
    int          rper = 10;

    dcf_top u0 (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .off_sel(off_sel),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_din(a_din),
        .full_n(full_n), .afull_n(afull_n),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_dout(b_dout),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #(rper / 2) rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int i);
        return 36'(i * 37 + 5) ^ 36'hF0F0F0F0F;
    endfunction

    task automatic settle();
        repeat (5) @(posedge rclk);
        repeat (5) @(posedge wclk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] s, input bit check_flags);
        @(posedge wclk); #1;
        rst_n = 1'b0; off_sel = s;
        a_cs_n = 1'b1; a_en = 1'b0; b_cs_n = 1'b1; b_en = 1'b0;
        repeat (12) @(posedge wclk);
        #1;
        if (check_flags) begin
            chk("R1 full_n in reset", 36'(full_n), 36'd0);
            chk("R1 afull_n in reset", 36'(afull_n), 36'd1);
            chk("R1 empty_n in reset", 36'(empty_n), 36'd0);
            chk("R1 aempty_n in reset", 36'(aempty_n), 36'd0);
        end
        rst_n = 1'b1;
        @(posedge wclk); #1;
        if (check_flags) chk("R2 full_n after first edge", 36'(full_n), 36'd0);
        @(posedge wclk); #1;
        if (check_flags) chk("R2 full_n after second edge", 36'(full_n), 36'd1);
        settle();
    endtask

    // drive one port-A cycle with the given qualifiers
    task automatic a_cycle(input logic cs_n, input logic en, input logic wr, input logic [35:0] d);
        @(posedge wclk); #1;
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_din = d;
        @(posedge wclk); #1;
        a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0;
    endtask

    task automatic b_cycle(input logic cs_n, input logic en, input logic wr);
        @(posedge rclk); #1;
        b_cs_n = cs_n; b_en = en; b_wr = wr;
        @(posedge rclk); #1;
        b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b1;
    endtask

    task automatic t_first_word();
        a_cycle(1'b0, 1'b1, 1'b1, 36'hA5A5A5A5A);
        @(posedge rclk); #1;
        chk("R4 empty_n after first read edge", 36'(empty_n), 36'd0);
        @(posedge rclk); #1;
        chk("R4 empty_n after second read edge", 36'(empty_n), 36'd1);
        b_cycle(1'b0, 1'b1, 1'b0);
        chk("R3 data of single word", b_dout, 36'hA5A5A5A5A);
        chk("R8 empty_n after last read", 36'(empty_n), 36'd0);
        b_cycle(1'b0, 1'b1, 1'b0);
        chk("R8 dout held on empty read", b_dout, 36'hA5A5A5A5A);
    endtask

    task automatic t_gating();
        a_cycle(1'b1, 1'b1, 1'b1, 36'h000000BAD);
        a_cycle(1'b0, 1'b0, 1'b1, 36'h000000BAD);
        a_cycle(1'b0, 1'b1, 1'b0, 36'h000000BAD);
        settle();
        chk("R10 no store from gated port A", 36'(empty_n), 36'd0);
        a_cycle(1'b0, 1'b1, 1'b1, 36'h000000111);
        settle();
        b_cycle(1'b0, 1'b1, 1'b1);
        b_cycle(1'b1, 1'b1, 1'b0);
        chk("R10 dout unchanged by gated port B", b_dout, 36'hA5A5A5A5A);
        chk("R10 word still stored", 36'(empty_n), 36'd1);
        b_cycle(1'b0, 1'b1, 1'b0);
        chk("R10 R3 word read after gated cycles", b_dout, 36'h000000111);
    endtask

    task automatic t_levels();
        do_reset(2'b00, 1'b0);
        for (int i = 0; i < 16; i++) a_cycle(1'b0, 1'b1, 1'b1, pat(i));
        settle();
        chk("R5 aempty_n at count 16", 36'(aempty_n), 36'd0);
        a_cycle(1'b0, 1'b1, 1'b1, pat(16));
        settle();
        chk("R5 aempty_n at count 17", 36'(aempty_n), 36'd1);
        for (int i = 17; i < 47; i++) a_cycle(1'b0, 1'b1, 1'b1, pat(i));
        settle();
        chk("R6 afull_n at free 17", 36'(afull_n), 36'd1);
        a_cycle(1'b0, 1'b1, 1'b1, pat(47));
        settle();
        chk("R6 afull_n at free 16", 36'(afull_n), 36'd0);
        for (int i = 48; i < 64; i++) a_cycle(1'b0, 1'b1, 1'b1, pat(i));
        settle();
        chk("R7 full_n at 64 words", 36'(full_n), 36'd0);
        a_cycle(1'b0, 1'b1, 1'b1, 36'hDEADDEADD);
        settle();
        chk("R7 full_n after dropped write", 36'(full_n), 36'd0);
        for (int i = 0; i < 64; i++) begin
            b_cycle(1'b0, 1'b1, 1'b0);
            chk("R3 R7 ordered data from full buffer", b_dout, pat(i));
        end
        settle();
        chk("R7 empty after 64 reads", 36'(empty_n), 36'd0);
        chk("R7 full_n released", 36'(full_n), 36'd1);
    endtask

    task automatic t_offsets();
        for (int s = 1; s < 4; s++) begin
            do_reset(2'(s), 1'b0);
            off_sel = ~2'(s);
            for (int i = 0; i < 16 - 4 * s; i++) a_cycle(1'b0, 1'b1, 1'b1, pat(i));
            settle();
            chk("R9 aempty_n at count X", 36'(aempty_n), 36'd0);
            a_cycle(1'b0, 1'b1, 1'b1, pat(99));
            settle();
            chk("R9 aempty_n at count X+1", 36'(aempty_n), 36'd1);
        end
    endtask

    task automatic t_stream();
        rper = 16;
        do_reset(2'b00, 1'b0);
        fork
            begin
                int  wi = 0;
                bit  pend = 0;
                while (wi < 100) begin
                    @(posedge wclk); #1;
                    if (pend) wi++;
                    pend = (wi < 100) && full_n;
                    a_cs_n = ~pend; a_en = pend; a_wr = pend; a_din = pat(wi);
                end
                a_cs_n = 1'b1; a_en = 1'b0;
            end
            begin
                int  ri = 0;
                bit  pend = 0;
                while (ri < 100) begin
                    @(posedge rclk); #1;
                    if (pend) begin
                        chk("R3 streamed data order", b_dout, pat(ri));
                        ri++;
                    end
                    pend = (ri < 100) && empty_n;
                    b_cs_n = ~pend; b_en = pend; b_wr = ~pend;
                end
                b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b1;
            end
        join
        settle();
        chk("R3 empty after stream", 36'(empty_n), 36'd0);
    endtask

    initial begin
        do_reset(2'b00, 1'b1);
        t_first_word();
        t_gating();
        t_levels();
        t_offsets();
        t_stream();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule